// File: doc/BRIEF.md
# SPI Client Serial Interface

This block is the target side of an SPI link. An external host drives the serial clock, the active-low select and the host-to-client data line. The block returns one character on MISO for every character it receives on MOSI. Both directions pass through a single shift register. Character length, clock polarity and clock phase are set through a configuration register. A small synchronous register port on the system clock gives local logic access to configuration, transmit data, receive data and status.

The serial inputs are oversampled. Select, serial clock and MOSI each pass through a synchronizer into the system clock domain, and serial clock edges are detected there. Bits are captured and shifted only on those detected edges. A character starts at a select falling edge. It also starts at the moment the previous character completes, if select is still low.

At each character start the shift register is loaded by a fixed priority:
1. If a transmit write is pending, the most recent one is loaded.
2. Otherwise, if the shift register already holds a character that has not been sent, it is kept.
3. Otherwise, if software has written transmit data at some point, the transmit holding value is sent again and the underrun flag is set.
4. Otherwise nothing is loaded, so the block sends back its last received character, or zeros after reset.

Top module: `spic_top`

## Requirements
- R1: After reset, status reads 0x0002 (only transmit-empty set) and RX reads 0. The shift register holds zero. MISO is low whenever select is inactive.
- R2: A character is 8 + code bits long, where code is the length field. Any code above 8 gives 16 bits. Bits travel most significant first.
- R3: The polarity bit sets the idle level of the serial clock. The leading edge leaves that idle level. With the phase bit set to 1, MOSI is captured on the leading edge and MISO changes on the trailing edge. With the phase bit at 0, MISO changes on the leading edge and capture happens on the trailing edge.
- R4: When the last bit of a character is captured, RX takes the received character (bits above the length read 0) and receive-ready is set. Reading RX clears receive-ready.
- R5: If a character completes while receive-ready is still set, overrun is set and RX is still overwritten. Overrun clears only on a status read.
- R6: While no transmit write has ever happened, each character sends the current shift register contents. That is all zeros after reset, and the last received character after that.
- R7: A transmit write made while select is inactive and the shift register holds no unsent character goes straight into the shift register, and transmit-empty stays 1. Any other transmit write is held and clears transmit-empty. Only the latest held value is loaded at the next character start, and that load sets transmit-empty.
- R8: At a character start with no transmit write since the previous load, and no unsent character already in the shift register, the transmit holding value is sent again and underrun is set. A status read clears underrun.
- R9: Serial clock edges have no effect while select is inactive. A select falling edge restarts the bit count.
- R10: With select held low, the next character starts as soon as the previous one completes, and R7 and R8 apply at that start.
- R11: Register map on reg_addr:
  - 0 is configuration: bits [3:0] length code, bit 4 polarity, bit 5 phase.
  - 1 is transmit data (write).
  - 2 is receive data (read).
  - 3 is status: bit 0 receive-ready, bit 1 transmit-empty, bit 2 overrun, bit 3 underrun.

  Read data is valid in the same cycle as reg_rd. Clear-on-read effects take place at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, low when not selected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
The assertions assume the host respects the oversampling limits:
- Each serial clock half period is several system clocks longer than the synchronizer delay.
- Select stays inactive for at least two system clocks between characters.
- No capture edge arrives within four system clocks after select rises.
- The configuration is changed only while select is inactive.
- No transmit write lands in the same cycle as a character start.

The stimulus holds each serial clock level for eight system clocks and waits the same time around every select edge. It changes configuration and writes transmit data only while select is high, or well inside a character.

// File: rtl/spic_pkg.sv
// Package: shared register addresses and status bit positions for the
// SPI client block. Assumes a two-bit register address.
package spic_pkg;

    // Register address map
    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_TX   = 2'd1,
        A_RX   = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // Status bit positions
    localparam int ST_RDY = 0;
    localparam int ST_TXE = 1;
    localparam int ST_OVR = 2;
    localparam int ST_UND = 3;

    // Configuration bit positions above the length code
    localparam int CFG_POL = 4;
    localparam int CFG_PHA = 5;

endpackage

// File: rtl/spic_front.sv
// Module: spic_front
// Brings select, serial clock and MOSI into the system clock domain through
// a SYNC_STAGES-deep synchronizer, then produces single-cycle capture and
// change pulses for the programmed polarity and phase.
// Assumes the serial clock is much slower than clk. Edges are suppressed
// while select is inactive and in the cycle select becomes active.
module spic_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic sel_n,
    input  logic mosi,
    input  logic cpol,
    input  logic lead_cap,
    output logic sel_act,
    output logic sel_fall,
    output logic cap_pulse,
    output logic chg_pulse,
    output logic mosi_bit
);

    localparam int NSIG = 3;
    localparam int I_SEL = 2;
    localparam int I_SCK = 1;
    localparam int I_DAT = 0;
    localparam int LAST = SYNC_STAGES - 1;

    logic [NSIG-1:0] stg [SYNC_STAGES];
    logic            sel_d;
    logic            sck_d;
    logic            sel_s;
    logic            sck_s;
    logic            rise;
    logic            fall;
    logic            lead;
    logic            trail;

    // Shift raw inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b100;
        end else begin
            stg[0] <= {sel_n, sck, mosi};
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    // Remember the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            sel_d <= sel_s;
            sck_d <= sck_s;
        end
    end

    // Edge classification from polarity and phase
    always_comb begin
        sel_s     = stg[LAST][I_SEL];
        sck_s     = stg[LAST][I_SCK];
        mosi_bit  = stg[LAST][I_DAT];
        sel_act   = ~sel_s;
        sel_fall  = ~sel_s & sel_d;
        rise      = sck_s & ~sck_d;
        fall      = ~sck_s & sck_d;
        lead      = cpol ? fall : rise;
        trail     = cpol ? rise : fall;
        cap_pulse = sel_act & ~sel_fall & (lead_cap ? lead : trail);
        chg_pulse = sel_act & ~sel_fall & (lead_cap ? trail : lead);
    end

endmodule

// File: rtl/spic_shift.sv
// Module: spic_shift
// Single shift register shared by both directions. MOSI enters at bit 0 on
// each capture pulse, and the output bit is taken from bit len-1. Counts
// captured bits and flags the last one of a character.
// Assumes len is between 2 and DATA_W, and that capture and change pulses
// never occur in the same cycle.
module spic_shift #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len,
    input  logic              sel_act,
    input  logic              sel_fall,
    input  logic              cap,
    input  logic              chg,
    input  logic              mosi_bit,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic              done,
    output logic              first_cap,
    output logic [DATA_W-1:0] rx_word,
    output logic              miso_q,
    output logic [LEN_W-1:0]  bit_cnt
);

    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mask;
    logic [IDX_W-1:0]  top_idx;
    logic [LEN_W-1:0]  last_idx;

    // Per-bit mask of the active character length
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_mask
            assign mask[b] = (LEN_W'(b) < len);
        end
    endgenerate

    // Next shift value, end-of-character detection and received word
    always_comb begin
        last_idx  = len - LEN_W'(1);
        top_idx   = IDX_W'(last_idx);
        shifted   = {sh[DATA_W-2:0], mosi_bit};
        done      = cap && (bit_cnt == last_idx);
        first_cap = cap && (bit_cnt == '0);
        rx_word   = shifted & mask;
    end

    // Shift register: a load overrides a capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load_en) begin
            sh <= load_val;
        end else if (cap) begin
            sh <= shifted;
        end
    end

    // Bit counter, restarted by select or by character completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (!sel_act || sel_fall) begin
            bit_cnt <= '0;
        end else if (cap) begin
            bit_cnt <= done ? '0 : bit_cnt + LEN_W'(1);
        end
    end

    // Output bit register, updated at load, select start and change edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
        end else if (load_en) begin
            miso_q <= load_val[top_idx];
        end else if (sel_fall || chg) begin
            miso_q <= sh[top_idx];
        end
    end

endmodule

// File: rtl/spic_regs.sv
// Module: spic_regs
// Register port, transmit holding register, receive register and status
// flags. Decides at every character start (and for a direct write while
// idle) whether the shift register is loaded, and from what.
// Assumes char_start is asserted only while select is active, and that a
// transmit write does not fall in the same cycle as char_start.
module spic_regs
    import spic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sel_act,
    input  logic              char_start,
    input  logic              done,
    input  logic              first_cap,
    input  logic [DATA_W-1:0] rx_word,
    output logic [CODE_W-1:0] len_code,
    output logic              cpol,
    output logic              lead_cap,
    output logic              load_en,
    output logic [DATA_W-1:0] load_val,
    output logic              rx_ready,
    output logic              tx_empty,
    output logic              overrun,
    output logic              underrun,
    output logic [DATA_W-1:0] rx_hold
);

    logic [DATA_W-1:0] tx_hold;
    logic              pend;
    logic              fresh;
    logic              tx_ever;
    logic              wr_cfg;
    logic              wr_tx;
    logic              rd_rx;
    logic              rd_stat;
    logic              direct;
    logic              take_pend;
    logic              und_evt;

    // Decode strobes and choose the shift register load
    always_comb begin
        wr_cfg    = reg_wr && (reg_addr == A_CFG);
        wr_tx     = reg_wr && (reg_addr == A_TX);
        rd_rx     = reg_rd && (reg_addr == A_RX);
        rd_stat   = reg_rd && (reg_addr == A_STAT);
        direct    = wr_tx && !sel_act && !fresh && !pend;
        take_pend = 1'b0;
        und_evt   = 1'b0;
        load_en   = 1'b0;
        load_val  = tx_hold;
        if (direct) begin
            load_en  = 1'b1;
            load_val = reg_wdata;
        end else if (char_start) begin
            if (pend) begin
                load_en   = 1'b1;
                take_pend = 1'b1;
            end else if (!fresh && tx_ever) begin
                load_en = 1'b1;
                und_evt = 1'b1;
            end
        end
    end

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_code <= '0;
            cpol     <= 1'b0;
            lead_cap <= 1'b0;
        end else if (wr_cfg) begin
            len_code <= reg_wdata[CODE_W-1:0];
            cpol     <= reg_wdata[CFG_POL];
            lead_cap <= reg_wdata[CFG_PHA];
        end
    end

    // Transmit holding register and its write history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_ever <= 1'b0;
        end else if (wr_tx) begin
            tx_hold <= reg_wdata;
            tx_ever <= 1'b1;
        end
    end

    // Pending flag and transmit-empty: a held write wins over a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            tx_empty <= 1'b1;
        end else if (wr_tx && !direct) begin
            pend     <= 1'b1;
            tx_empty <= 1'b0;
        end else if (take_pend || direct) begin
            pend     <= 1'b0;
            tx_empty <= 1'b1;
        end
    end

    // Fresh flag: the shift register holds a character not yet started
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh <= 1'b0;
        end else if (direct || char_start) begin
            fresh <= 1'b1;
        end else if (first_cap) begin
            fresh <= 1'b0;
        end
    end

    // Underrun flag: set on a resend, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (und_evt) begin
            underrun <= 1'b1;
        end else if (rd_stat) begin
            underrun <= 1'b0;
        end
    end

    // Receive register and receive-ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold  <= '0;
            rx_ready <= 1'b0;
        end else if (done) begin
            rx_hold  <= rx_word;
            rx_ready <= 1'b1;
        end else if (rd_rx) begin
            rx_ready <= 1'b0;
        end
    end

    // Overrun flag: set on completion with unread data, cleared by status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (done && rx_ready) begin
            overrun <= 1'b1;
        end else if (rd_stat) begin
            overrun <= 1'b0;
        end
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[CODE_W-1:0] = len_code;
                reg_rdata[CFG_POL]    = cpol;
                reg_rdata[CFG_PHA]    = lead_cap;
            end
            A_TX:  reg_rdata = tx_hold;
            A_RX:  reg_rdata = rx_hold;
            default: begin
                reg_rdata[ST_RDY] = rx_ready;
                reg_rdata[ST_TXE] = tx_empty;
                reg_rdata[ST_OVR] = overrun;
                reg_rdata[ST_UND] = underrun;
            end
        endcase
    end

endmodule

// File: rtl/spic_top.sv
// Module: spic_top
// SPI client: input synchronizer and edge detection, shared shift register,
// and register port with the transmit/receive flags. A character starts at a
// select falling edge, or at completion of the previous character while
// select stays low.
// Assumes the serial clock half period is well above SYNC_STAGES+1 system
// clocks.
module spic_top #(
    parameter int DATA_W      = 16,
    parameter int MIN_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sel_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int CODE_W = $clog2(DATA_W - MIN_BITS + 1);
    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int SPAN   = DATA_W - MIN_BITS;

    logic              sel_act;
    logic              sel_fall;
    logic              cap;
    logic              chg;
    logic              mosi_bit;
    logic              cpol;
    logic              lead_cap;
    logic [CODE_W-1:0] len_code;
    logic [LEN_W-1:0]  char_len;
    logic              load_en;
    logic [DATA_W-1:0] load_val;
    logic              done;
    logic              first_cap;
    logic [DATA_W-1:0] rx_word;
    logic              miso_q;
    logic [LEN_W-1:0]  bit_cnt;
    logic              char_start;
    logic              rx_ready;
    logic              tx_empty;
    logic              overrun;
    logic              underrun;
    logic [DATA_W-1:0] rx_hold;

    // Character length from the code, clamped to the register width
    always_comb begin
        if (len_code > CODE_W'(SPAN)) begin
            char_len = LEN_W'(DATA_W);
        end else begin
            char_len = LEN_W'(MIN_BITS) + LEN_W'(len_code);
        end
    end

    // Character start events and gated serial output
    always_comb begin
        char_start = sel_fall | done;
        miso       = miso_q & sel_act;
    end

    spic_front #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sel_n    (sel_n),
        .mosi     (mosi),
        .cpol     (cpol),
        .lead_cap (lead_cap),
        .sel_act  (sel_act),
        .sel_fall (sel_fall),
        .cap_pulse(cap),
        .chg_pulse(chg),
        .mosi_bit (mosi_bit)
    );

    spic_shift #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .len      (char_len),
        .sel_act  (sel_act),
        .sel_fall (sel_fall),
        .cap      (cap),
        .chg      (chg),
        .mosi_bit (mosi_bit),
        .load_en  (load_en),
        .load_val (load_val),
        .done     (done),
        .first_cap(first_cap),
        .rx_word  (rx_word),
        .miso_q   (miso_q),
        .bit_cnt  (bit_cnt)
    );

    spic_regs #(
        .DATA_W(DATA_W),
        .CODE_W(CODE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sel_act   (sel_act),
        .char_start(char_start),
        .done      (done),
        .first_cap (first_cap),
        .rx_word   (rx_word),
        .len_code  (len_code),
        .cpol      (cpol),
        .lead_cap  (lead_cap),
        .load_en   (load_en),
        .load_val  (load_val),
        .rx_ready  (rx_ready),
        .tx_empty  (tx_empty),
        .overrun   (overrun),
        .underrun  (underrun),
        .rx_hold   (rx_hold)
    );

endmodule

// File: rtl/spic_check.sv
// Module: spic_check
// Assertion checker bound into spic_top. Observes the register port, the
// completion and start events, the flags and the bit counter.
// Assumes the host respects the select and serial clock spacing rules.
module spic_check
    import spic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic              sel_act,
    input logic              done,
    input logic              char_start,
    input logic              rx_ready,
    input logic              tx_empty,
    input logic              overrun,
    input logic              underrun,
    input logic [DATA_W-1:0] rx_hold,
    input logic [LEN_W-1:0]  bit_cnt,
    input logic [LEN_W-1:0]  char_len
);

    AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);                                                   // R4

    AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_hold));                                          // R4

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_ready) |=> overrun);                                      // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(reg_rd && reg_addr == A_STAT)) |=> overrun);            // R5

    AST_UND_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(char_start));                               // R8

    AST_TXE_HELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TX && sel_act) |=> !tx_empty);               // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < char_len);                                                  // R2

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> (bit_cnt == '0));                                        // R9

endmodule

bind spic_top spic_check #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .sel_act   (sel_act),
    .done      (done),
    .char_start(char_start),
    .rx_ready  (rx_ready),
    .tx_empty  (tx_empty),
    .overrun   (overrun),
    .underrun  (underrun),
    .rx_hold   (rx_hold),
    .bit_cnt   (bit_cnt),
    .char_len  (char_len)
);

// File: tb/spic_top_test.sv
// Bench for spic_top: a vector table over lengths and clock modes, then
// directed tests for reset state, resend rules, overrun, underrun, ignored
// clocks and back-to-back characters.
module spic_top_test;

    localparam int NV = 8;
    localparam int VW = 38;
    // {code[3:0], cpol, lead, tx[15:0], mosi[15:0]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd0,  1'b0, 1'b1, 16'h00A5, 16'h003C},
        {4'd0,  1'b1, 1'b1, 16'h0081, 16'h00F0},
        {4'd0,  1'b0, 1'b0, 16'h0096, 16'h000F},
        {4'd0,  1'b1, 1'b0, 16'h004B, 16'h00D2},
        {4'd4,  1'b0, 1'b1, 16'h0ABC, 16'h035E},
        {4'd8,  1'b1, 1'b0, 16'hBEEF, 16'h1234},
        {4'd13, 1'b0, 1'b0, 16'hC3A5, 16'h5AC3},
        {4'd3,  1'b1, 1'b1, 16'hFFFF, 16'h0555}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        sel_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spic_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sel_n    (sel_n),
        .mosi     (mosi),
        .miso     (miso),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic begin_sel(input logic cpol);
        @(negedge clk);
        sck = cpol;
        repeat (4) @(negedge clk);
        sel_n = 1'b0;
        wait_half();
    endtask

    task automatic end_sel();
        wait_half();
        sel_n = 1'b1;
        wait_half();
    endtask

    task automatic shift_char(input int len, input logic cpol, input logic lead,
                              input logic [15:0] din, output logic [15:0] dout);
        dout = 16'h0;
        for (int i = len - 1; i >= 0; i--) begin
            if (lead) begin
                mosi = din[i];
                wait_half();
                dout[i] = miso;
                sck = ~cpol;
                wait_half();
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = din[i];
                wait_half();
                dout[i] = miso;
                sck = cpol;
                wait_half();
            end
        end
    endtask

    task automatic xfer(input int len, input logic cpol, input logic lead,
                        input logic [15:0] din, output logic [15:0] dout);
        begin_sel(cpol);
        shift_char(len, cpol, lead, din, dout);
        end_sel();
    endtask

    function automatic int len_of(input logic [3:0] code);
        return (code > 4'd8) ? 16 : 8 + int'(code);
    endfunction

    function automatic logic [15:0] mask_of(input int len);
        return (len >= 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] got;
        do_reset();

        // R1: reset state
        chk("R1", "miso idle", {15'h0, miso}, 16'h0);
        rd(2'd3, r); chk("R1", "status after reset", r, 16'h0002);
        rd(2'd2, r); chk("R1", "rx after reset", r, 16'h0000);

        // Vector table: lengths (R2), modes (R3), receive (R4), loads (R7), resend (R8)
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  code;
            logic        cp;
            logic        ld;
            logic [15:0] txv;
            logic [15:0] rxv;
            logic [15:0] m;
            int          n;
            {code, cp, ld, txv, rxv} = VEC[v];
            n = len_of(code);
            m = mask_of(n);
            wr(2'd0, {10'h0, ld, cp, code});
            rd(2'd0, r); chk("R11", "config readback", r, {10'h0, ld, cp, code});
            wr(2'd1, txv);
            rd(2'd3, r);
            chk("R7", "status before transfer", r, (v == 0) ? 16'h0002 : 16'h0000);
            xfer(n, cp, ld, rxv, got);
            chk("R3", "miso character", got, txv & m);
            rd(2'd3, r); chk("R8", "status after transfer", r, 16'h000B);
            rd(2'd2, r); chk("R2", "rx character", r, rxv & m);
            rd(2'd3, r); chk("R4", "ready cleared by rx read", r, 16'h0002);
        end

        // Directed tests from a fresh reset
        do_reset();
        chk("R1", "miso idle after reset", {15'h0, miso}, 16'h0);
        rd(2'd3, r); chk("R1", "status after second reset", r, 16'h0002);
        wr(2'd0, 16'h0020);

        // R6: nothing written, zeros go out
        xfer(8, 1'b0, 1'b1, 16'h006D, got);
        chk("R6", "zeros after reset", got, 16'h0000);
        rd(2'd3, r); chk("R6", "no underrun without writes", r, 16'h0003);

        // R6: last received goes out; R5: overrun with overwrite
        xfer(8, 1'b0, 1'b1, 16'h0092, got);
        chk("R6", "last received resent", got, 16'h006D);
        rd(2'd3, r); chk("R5", "overrun set", r, 16'h0007);
        rd(2'd3, r); chk("R5", "overrun cleared by status read", r, 16'h0003);
        rd(2'd2, r); chk("R5", "rx overwritten", r, 16'h0092);

        // R9: clock edges while select inactive are ignored
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            sck = ~sck;
            mosi = ~mosi;
            repeat (3) @(negedge clk);
        end
        rd(2'd3, r); chk("R9", "no character from idle clocks", r, 16'h0002);
        xfer(8, 1'b0, 1'b1, 16'h00E1, got);
        chk("R9", "bit alignment after idle clocks", got, 16'h0092);
        rd(2'd2, r); chk("R9", "rx after idle clocks", r, 16'h00E1);

        // R7: held writes, latest wins
        wr(2'd1, 16'h0011);
        wr(2'd1, 16'h0022);
        rd(2'd3, r); chk("R7", "transmit-empty cleared by held write", r, 16'h0000);
        xfer(8, 1'b0, 1'b1, 16'h0000, got);
        chk("R7", "latest write sent", got, 16'h0022);
        rd(2'd3, r); chk("R7", "transmit-empty set after load", r, 16'h000B);
        rd(2'd2, r);

        // R8: no new write, holding value resent with underrun
        xfer(8, 1'b0, 1'b1, 16'h0055, got);
        chk("R8", "holding value resent", got, 16'h0022);
        rd(2'd3, r); chk("R8", "underrun set", r, 16'h000B);
        rd(2'd2, r);
        rd(2'd3, r); chk("R8", "underrun cleared by status read", r, 16'h0002);

        // R10: back-to-back characters with a write held during the first
        wr(2'd1, 16'h003C);
        begin_sel(1'b0);
        wr(2'd1, 16'h00C3);
        shift_char(8, 1'b0, 1'b1, 16'h00AA, got);
        chk("R10", "first back-to-back character", got, 16'h003C);
        shift_char(8, 1'b0, 1'b1, 16'h0077, got);
        chk("R10", "second back-to-back character", got, 16'h00C3);
        end_sel();
        rd(2'd3, r); chk("R10", "status after back-to-back", r, 16'h000F);
        rd(2'd2, r); chk("R10", "rx after back-to-back", r, 16'h0077);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule